// File: doc/BRIEF.md
# Serial Display-RAM Access Port

This block is the host-facing slave of a segment display controller. A host drives an active-low chip select, a write strobe, a read strobe and a data line. It uses them to reach a 96-nibble display memory held inside the block, and to issue 9-bit configuration commands. All four pins are brought into the fast internal clock through two-flop synchronisers. Strobe edges are found in that clock domain, so the host strobes must be slow compared with the internal clock.

Each frame opens with a 3-bit mode code. A data frame then carries a 7-bit address and a run of nibbles at consecutive addresses. In read-modify-write, the host first reads a nibble with the read strobe and then rewrites the same location with the write strobe. A command frame carries any number of 9-bit commands back to back. Each recognised command produces a one-cycle pulse on one bit of a strobe vector. The LCD waveform logic, the tone and timer logic and the clock sources sit outside this block and consume those pulses.

Top module: `ser_disp_if`

## Requirements
- R1: After reset, and whenever chip select is high, no transfer takes place, the data output enable is low and no strobe fires. A frame that is cut short by chip select rising is discarded, and the next frame must start with a new mode code.
- R2: Mode code 101, sent MSB first on write-strobe rising edges, selects a data frame. A 7-bit address follows, MSB first. Then 4-bit nibbles follow, least significant bit first, and each completed nibble is stored at the current address.
- R3: Mode code 110 selects a read frame. After the 7-bit address, each falling edge of the read strobe presents the next bit of the stored nibble on data_o, least significant bit first, valid by the following rising edge.
- R4: After every nibble, whether written or read, the address advances by one. From address 95 it wraps to 0.
- R5: Addresses 96 to 127 hold no storage: writes there change nothing, and reads there return 0.
- R6: In a 101 frame, read-strobe pulses before the write nibble return the old contents of the current address. The write nibble that follows then replaces that same address, and only then does the address advance.
- R7: Mode code 100 selects command mode. Each command is 9 bits, MSB first, and bit 0 is ignored. With the remaining 8 bits written MSB first, these strobe bits pulse for exactly one cycle: 00000000 -> bit 0 (system off), 00000001 -> bit 1 (system on), 00000010 -> bit 2 (display off), 00000011 -> bit 3 (display on), 00001000 -> bit 4 (tone off), 010xxxxx -> bit 5 (tone high), 0110xxxx -> bit 6 (tone low), 100x0xxx -> bit 7 (interrupt disable), 100x1xxx -> bit 8 (interrupt enable). At most one bit is high at a time.
- R8: While chip select stays low, further 9-bit commands follow one another without a repeated mode code.
- R9: A command matching none of the codes in R7, and any frame whose mode code is not 110, 101 or 100, produces no strobe.
- R10: data_oe_o is high only while chip select is low and the block is in a read phase: a 110 frame after its address, or the read part of a read-modify-write. It is low during write, address and command phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, much faster than the host strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select from host, active low |
| wr_i | input | 1 | Write strobe; data is sampled on its rising edge |
| rd_i | input | 1 | Read strobe; data is driven after its falling edge |
| data_i | input | 1 | Serial data from the host |
| data_o | output | 1 | Serial read data toward the host |
| data_oe_o | output | 1 | Output enable for the shared data pad |
| cmd_stb_o | output | 9 | One-cycle command strobes, bit map in R7 |

## Verification
The hardest situation to reach is read-modify-write. There the same 101 frame interleaves read-strobe pulses with write-strobe pulses, and the address must hold through the read half and step only after the write nibble. The bench reaches it with two nibbles in a row at locations it filled earlier. It checks the old values as they are clocked out, then reads the region back in a fresh frame to confirm the new values and the single step per nibble. The 95-to-0 wrap and the aborted frame each come from a dedicated frame that stops or crosses at exactly that point.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  localparam int ADDR_W = 7;
  localparam int NIB_W  = 4;
  localparam int CMD_W  = 9;
  localparam int N_STB  = 9;

  localparam int STB_SYS_OFF  = 0;
  localparam int STB_SYS_ON   = 1;
  localparam int STB_LCD_OFF  = 2;
  localparam int STB_LCD_ON   = 3;
  localparam int STB_TONE_OFF = 4;
  localparam int STB_TONE_HI  = 5;
  localparam int STB_TONE_LO  = 6;
  localparam int STB_IRQ_DIS  = 7;
  localparam int STB_IRQ_EN   = 8;

  typedef enum logic [2:0] {
    ST_ID, ST_ADDR, ST_RDATA, ST_WDATA, ST_CMD, ST_SKIP
  } sdi_state_e;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sdi_ram.sv
module sdi_ram #(
  parameter int DEPTH = 96,
  parameter int AW    = 7,
  parameter int DW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && waddr_i <= LAST) mem[waddr_i] <= wdata_i;
  end

  // unbacked addresses read as zero
  assign rdata_o = (raddr_i <= LAST) ? mem[raddr_i] : '0;
endmodule

// File: rtl/sdi_cmd_dec.sv
module sdi_cmd_dec
  import sdi_pkg::*;
(
  input  logic [CMD_W-2:0] code_i,
  output logic [N_STB-1:0] hit_o
);
  always_comb begin
    hit_o = '0;
    casez (code_i)
      8'b0000_0000: hit_o[STB_SYS_OFF]  = 1'b1;
      8'b0000_0001: hit_o[STB_SYS_ON]   = 1'b1;
      8'b0000_0010: hit_o[STB_LCD_OFF]  = 1'b1;
      8'b0000_0011: hit_o[STB_LCD_ON]   = 1'b1;
      8'b0000_1000: hit_o[STB_TONE_OFF] = 1'b1;
      8'b010?_????: hit_o[STB_TONE_HI]  = 1'b1;
      8'b0110_????: hit_o[STB_TONE_LO]  = 1'b1;
      8'b100?_0???: hit_o[STB_IRQ_DIS]  = 1'b1;
      8'b100?_1???: hit_o[STB_IRQ_EN]   = 1'b1;
      default:      hit_o = '0;
    endcase
  end
endmodule

// File: rtl/ser_disp_if.sv
module ser_disp_if
  import sdi_pkg::*;
#(
  parameter int DEPTH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             data_i,
  output logic             data_o,
  output logic             data_oe_o,
  output logic [N_STB-1:0] cmd_stb_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [3:0] pins_s;
  logic cs_s, wr_s, rd_s, din_s;
  logic wr_d, rd_d;

  sdi_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_i, rd_i, data_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, wr_s, rd_s, din_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
    end else begin
      wr_d <= wr_s;
      rd_d <= rd_s;
    end
  end

  logic wr_rise, rd_fall, rd_rise;
  assign wr_rise = wr_s & ~wr_d;
  assign rd_fall = ~rd_s & rd_d;
  assign rd_rise = rd_s & ~rd_d;

  sdi_state_e        st;
  logic [CMD_W-1:0]  sh;
  logic [CMD_W-1:0]  sh_next;
  logic [3:0]        cnt;
  logic              is_rd;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_inc;
  logic [NIB_W-2:0]  wnib;
  logic [2:0]        rbits;
  logic              rd_act;
  logic              data_q, oe_q;
  logic [N_STB-1:0]  stb_q;
  logic [N_STB-1:0]  dec_hit;
  logic [NIB_W-1:0]  rd_nib;
  logic              ram_we;
  logic [NIB_W-1:0]  ram_wdata;

  assign sh_next  = {sh[CMD_W-2:0], din_s};
  assign addr_inc = (addr == LAST) ? '0 : addr + 1'b1;

  sdi_cmd_dec u_dec (
    .code_i(sh_next[CMD_W-1:1]),
    .hit_o (dec_hit)
  );

  assign ram_we    = wr_rise && !cs_s && st == ST_WDATA && cnt == 4'd3;
  assign ram_wdata = {din_s, wnib};

  sdi_ram #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(NIB_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(addr),
    .wdata_i(ram_wdata),
    .raddr_i(addr),
    .rdata_o(rd_nib)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_ID;
      sh     <= '0;
      cnt    <= '0;
      is_rd  <= 1'b0;
      addr   <= '0;
      wnib   <= '0;
      rbits  <= '0;
      rd_act <= 1'b0;
      data_q <= 1'b1;
      oe_q   <= 1'b0;
      stb_q  <= '0;
    end else begin
      stb_q <= '0;
      oe_q  <= ~cs_s & (st == ST_RDATA || rd_act);
      if (cs_s) begin
        st     <= ST_ID;
        cnt    <= '0;
        rbits  <= '0;
        rd_act <= 1'b0;
      end else begin
        if (wr_rise) begin
          unique case (st)
            ST_ID: begin
              sh  <= sh_next;
              cnt <= cnt + 1'b1;
              if (cnt == 4'd2) begin
                cnt <= '0;
                unique case (sh_next[2:0])
                  3'b110:  begin st <= ST_ADDR; is_rd <= 1'b1; end
                  3'b101:  begin st <= ST_ADDR; is_rd <= 1'b0; end
                  3'b100:  st <= ST_CMD;
                  default: st <= ST_SKIP;
                endcase
              end
            end
            ST_ADDR: begin
              sh  <= sh_next;
              cnt <= cnt + 1'b1;
              if (cnt == 4'd6) begin
                cnt    <= '0;
                addr   <= sh_next[ADDR_W-1:0];
                st     <= is_rd ? ST_RDATA : ST_WDATA;
                rbits  <= '0;
                rd_act <= 1'b0;
              end
            end
            ST_WDATA: begin
              cnt <= cnt + 1'b1;
              if (cnt != 4'd3) wnib[cnt[1:0]] <= din_s;
              else begin
                cnt    <= '0;
                addr   <= addr_inc;
                rbits  <= '0;
                rd_act <= 1'b0;
              end
            end
            ST_CMD: begin
              sh  <= sh_next;
              cnt <= cnt + 1'b1;
              if (cnt == 4'd8) begin
                cnt   <= '0;
                stb_q <= dec_hit;
              end
            end
            default: ;
          endcase
        end
        if (rd_fall && st == ST_RDATA) begin
          data_q <= rd_nib[cnt[1:0]];
          cnt    <= cnt + 1'b1;
          if (cnt == 4'd3) begin
            cnt  <= '0;
            addr <= addr_inc;
          end
        end
        // read half of read-modify-write: address held until write nibble
        if (rd_fall && st == ST_WDATA && rbits != 3'd4) begin
          data_q <= rd_nib[rbits[1:0]];
          rbits  <= rbits + 1'b1;
          rd_act <= 1'b1;
        end
        if (rd_rise && rbits == 3'd4) rd_act <= 1'b0;
      end
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
  assign cmd_stb_o = stb_q;
endmodule

// File: rtl/sdi_checker.sv
module sdi_checker
  import sdi_pkg::*;
#(
  parameter int DEPTH = 96
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              data_oe_o,
  input logic [N_STB-1:0]  cmd_stb_o,
  input logic              ram_we,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  a_r10_oe_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !data_oe_o);

  a_r1_quiet_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> cmd_stb_o == '0);

  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_stb_o));

  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_stb_o) |=> cmd_stb_o == '0);

  a_r4_wrap_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && addr == LAST) |=> addr == '0);
endmodule

bind ser_disp_if sdi_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .data_oe_o(data_oe_o),
  .cmd_stb_o(cmd_stb_o),
  .ram_we   (ram_we),
  .addr     (addr)
);

// File: tb/ser_disp_if_test.sv
module ser_disp_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, wr_i = 1'b1, rd_i = 1'b1, data_i = 1'b1;
  logic data_o, data_oe_o;
  logic [8:0] cmd_stb_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_disp_if uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_i(wr_i), .rd_i(rd_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .cmd_stb_o(cmd_stb_o)
  );

  typedef struct { logic b; string tag; } rd_item_t;
  typedef struct { logic [8:0] v; string tag; } stb_item_t;

  rd_item_t  exp_rd[$];
  stb_item_t exp_stb[$];
  rd_item_t  ri;
  stb_item_t si;
  logic [3:0] model [128];
  logic [6:0] cur;
  int n_chk = 0, n_err = 0;
  bit started = 0, done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_bit(logic b);
    data_i = b; wait_clk(HALF);
    wr_i = 1'b0; wait_clk(HALF);
    wr_i = 1'b1; wait_clk(HALF);
  endtask

  task automatic send(int val, int n);
    for (int i = n - 1; i >= 0; i--) wr_bit(val[i]);
  endtask

  task automatic rd_pulse();
    rd_i = 1'b0; wait_clk(HALF);
    rd_i = 1'b1; wait_clk(HALF);
  endtask

  task automatic open_frame(logic [2:0] id, logic [6:0] a);
    cs_ni = 1'b0; wait_clk(HALF);
    send(id, 3);
    send(a, 7);
    cur = a;
  endtask

  task automatic close_frame();
    cs_ni = 1'b1; wait_clk(3 * HALF);
  endtask

  function automatic logic [6:0] nxt(logic [6:0] a);
    return (a == 7'd95) ? 7'd0 : a + 7'd1;
  endfunction

  task automatic write_nib(logic [3:0] v, string tag);
    for (int i = 0; i < 4; i++) wr_bit(v[i]);
    if (cur < 7'd96) model[cur] = v;
    chk(data_oe_o == 1'b0, {tag, " R10 oe low in write"}, data_oe_o, 0);
    cur = nxt(cur);
  endtask

  task automatic read_nib(string tag);
    logic [3:0] e;
    e = (cur < 7'd96) ? model[cur] : 4'h0;
    for (int i = 0; i < 4; i++) begin
      exp_rd.push_back('{e[i], tag});
      rd_pulse();
    end
    cur = nxt(cur);
  endtask

  task automatic rmw_nib(logic [3:0] v, string tag);
    logic [3:0] e;
    e = model[cur];
    for (int i = 0; i < 4; i++) begin
      exp_rd.push_back('{e[i], tag});
      rd_pulse();
    end
    write_nib(v, tag);
  endtask

  task automatic cmd(logic [8:0] code, logic [8:0] exp, string tag);
    if (exp != 0) exp_stb.push_back('{exp, tag});
    send(code, 9);
    wait_clk(4);
  endtask

  // monitor: read bits at host sampling edge
  always @(posedge rd_i) begin
    if (started && !cs_ni) begin
      if (exp_rd.size() == 0) chk(0, "R3 unexpected read", data_o, 0);
      else begin
        ri = exp_rd.pop_front();
        chk(data_o == ri.b && data_oe_o, ri.tag, {data_oe_o, data_o}, {1'b1, ri.b});
      end
    end
  end

  // monitor: command strobes
  always @(negedge clk) begin
    if (started && cmd_stb_o != 0) begin
      if (exp_stb.size() == 0) chk(0, "R9 unexpected strobe", cmd_stb_o, 0);
      else begin
        si = exp_stb.pop_front();
        chk(cmd_stb_o == si.v, si.tag, cmd_stb_o, si.v);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    wait_clk(3);
    chk(data_oe_o == 1'b0 && cmd_stb_o == 0, "R1 reset outputs", {data_oe_o, cmd_stb_o}, 0);
    rst_ni = 1'b1;
    wait_clk(5);
    started = 1;
    chk(data_oe_o == 1'b0 && cmd_stb_o == 0, "R1 idle outputs", {data_oe_o, cmd_stb_o}, 0);

    // R2 R4 write run
    open_frame(3'b101, 7'd5);
    write_nib(4'h3, "R2 w5");
    write_nib(4'hA, "R4 w6");
    write_nib(4'hC, "R4 w7");
    close_frame();

    // R3 R4 read run
    open_frame(3'b110, 7'd5);
    read_nib("R3 r5");
    read_nib("R4 r6");
    read_nib("R4 r7");
    chk(data_oe_o == 1'b1, "R10 oe high in read phase", data_oe_o, 1);
    close_frame();
    chk(data_oe_o == 1'b0, "R10 oe low after deselect", data_oe_o, 0);

    // R4 wrap
    open_frame(3'b101, 7'd94);
    write_nib(4'h1, "R4 w94");
    write_nib(4'h2, "R4 w95");
    write_nib(4'h3, "R4 w0 after wrap");
    close_frame();
    open_frame(3'b110, 7'd95);
    read_nib("R4 r95");
    read_nib("R4 r0 after wrap");
    close_frame();

    // R5 unbacked address
    open_frame(3'b101, 7'd100);
    write_nib(4'hF, "R5 w100");
    close_frame();
    open_frame(3'b110, 7'd100);
    read_nib("R5 r100 zero");
    close_frame();

    // R6 read-modify-write at 5 and 6
    open_frame(3'b101, 7'd5);
    rmw_nib(4'h7, "R6 rmw5");
    rmw_nib(4'h9, "R6 rmw6");
    close_frame();
    open_frame(3'b110, 7'd5);
    read_nib("R6 r5 new");
    read_nib("R6 r6 new");
    read_nib("R6 r7 untouched");
    close_frame();

    // R1 aborted frame then fresh mode code
    cs_ni = 1'b0; wait_clk(HALF);
    send(2'b10, 2);
    close_frame();
    open_frame(3'b101, 7'd20);
    write_nib(4'h6, "R1 write after abort");
    close_frame();
    open_frame(3'b110, 7'd20);
    read_nib("R1 readback after abort");
    close_frame();

    // R7 R8 command stream, single mode code
    cs_ni = 1'b0; wait_clk(HALF);
    send(3'b100, 3);
    chk(data_oe_o == 1'b0, "R10 oe low in command", data_oe_o, 0);
    cmd(9'b000000000, 9'h001, "R7 system off");
    cmd(9'b000000010, 9'h002, "R8 system on");
    cmd(9'b000000100, 9'h004, "R8 display off");
    cmd(9'b000000111, 9'h008, "R7 display on low bit set");
    cmd(9'b000010001, 9'h010, "R7 tone off");
    cmd(9'b010101011, 9'h020, "R7 tone high");
    cmd(9'b011011110, 9'h040, "R7 tone low");
    cmd(9'b000001000, 9'h000, "R9 unmatched code");
    cmd(9'b100101110, 9'h080, "R7 irq disable");
    cmd(9'b100011011, 9'h100, "R8 irq enable");
    close_frame();

    // R9 unknown mode code
    cs_ni = 1'b0; wait_clk(HALF);
    send(3'b111, 3);
    send(9'b000000010, 9);
    wait_clk(4);
    close_frame();

    wait_clk(10);
    chk(exp_stb.size() == 0, "R7 all strobes seen", exp_stb.size(), 0);
    chk(exp_rd.size() == 0, "R3 all read bits seen", exp_rd.size(), 0);
    done = 1;
    finish_run();
  end
endmodule